// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous Memory

This block is a single-port synchronous memory whose transfers are pipelined so that the bus direction can change on any cycle. On one rising edge it samples an address together with the read/write select, the byte-lane write enables, an advance/load strobe and three chip enables. The data transfer for that access happens on the second enabled edge after it. For a read, the word shows on a registered output bus. For a write, the word is taken from the data-in bus. Because every access takes the same two-cycle slot, reads and writes can be issued back to back in any order with no idle cycle.

Write data arrives late, so a write is held in a small write buffer before it reaches the array. A read issued one or two cycles after a write to the same word picks up the new bytes through a forwarding path, lane by lane. A clock enable freezes the whole pipeline. An asynchronous output enable forces the data-out bus to zero at any time. The advance strobe lets one loaded address produce a short linear burst that wraps within an aligned group of four words.

Top module: `zbt_mem_top`

## Requirements
- R1: While `rst` is high at a rising edge, `rvalid` becomes 0 and the output register becomes 0, so `rdata` reads 0.
- R2: A selected read that is loaded on enabled edge n puts its word on `rdata`, with `rvalid`=1, just after enabled edge n+2. It returns every write that was issued earlier.
- R3: For a selected write loaded on enabled edge n, the word is taken from `wdata` at enabled edge n+2 and stored at the sampled address.
- R4: A word has four lanes. Lane i is data bits [8i+7:8i] plus parity bit 32+i. A write changes only the lanes whose `byte_we[i]` is 1 (sampled with the address), and the other lanes keep their old content.
- R5: Reads and writes may alternate on consecutive cycles with no idle slot. A read issued one or two cycles after a write to the same address returns the merged new lanes.
- R6: When `clk_en` is 0 at an edge, every input is ignored and all state holds, including `rvalid` and the output register.
- R7: A load (`adv_ld`=0) is a selected access only when `sel0`=1, `sel1`=1 and `sel2_n`=0. Any other load writes nothing and gives `rvalid`=0 in its data phase. An advance cycle ignores the chip enables.
- R8: An access that has already been accepted completes its data phase even when the following cycles are deselected.
- R9: `out_en`=0 forces `rdata` to 0 at once, without waiting for a clock edge. Restoring it shows the held output word again.
- R10: When the data phase belongs to a write or to an unselected slot, `rvalid` is 0 and `rdata` is 0.
- R11: An advance cycle (`adv_ld`=1) repeats the operation type of the last load. Its address has the upper bits of that load and low two bits equal to the loaded low bits plus the advance count, modulo 4. The byte enables are sampled anew. If the last load was unselected, advance cycles are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | 1 = pipeline advances; 0 = everything holds |
| sel0 | input | 1 | Chip enable, active high |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| rd_wr | input | 1 | 1 = read, 0 = write (used on loads) |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| byte_we | input | 4 | Per-lane write enables, sampled with the address |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data, taken two enabled edges after its address |
| out_en | input | 1 | Asynchronous output enable, active high |
| rdata | output | 36 | Registered read data, zero when idle or disabled |
| rvalid | output | 1 | Registered flag: rdata holds a read result |

## Verification
The bench builds the block with ADDR_W=4, which gives 16 words and four burst groups. Random addresses therefore collide often, so reads that follow a write to the same word by one or two cycles show up many times. This makes both forwarding sources and every burst wrap offset reachable in a short run. Clock-enable stalls are placed at random between those dependent accesses, so the held pipeline also has to keep a pending write and a forwarded read intact.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int LANES     = 4;
    localparam int LANE_BITS = 8;
    localparam int DATA_BITS = LANES * LANE_BITS;
    localparam int WORD_BITS = DATA_BITS + LANES;
    localparam int BURST_LG  = 2;

    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [LANES-1:0]     be_t;

    typedef struct packed {
        logic valid;
        logic rd;
        be_t  be;
    } op_ctl_t;

    // overlay the enabled lanes (data byte plus its parity bit) of nw onto old
    function automatic word_t lane_merge(word_t old, word_t nw, be_t be);
        word_t r;
        r = old;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) begin
                r[i*LANE_BITS +: LANE_BITS] = nw[i*LANE_BITS +: LANE_BITS];
                r[DATA_BITS + i]            = nw[DATA_BITS + i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/zbt_addr_gen.sv
module zbt_addr_gen
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sel_ok,
    input  logic              rd_wr,
    input  logic              adv_ld,
    input  logic [ADDR_W-1:0] addr,
    input  be_t               be,
    output op_ctl_t           op_ctl,
    output logic [ADDR_W-1:0] op_addr
);

    localparam int BL = BURST_LG;

    logic              b_act;
    logic              b_rd;
    logic [ADDR_W-1:0] b_base;
    logic [BL-1:0]     b_cnt;
    logic [BL-1:0]     b_off;

    assign b_off = b_base[BL-1:0] + b_cnt + {{(BL-1){1'b0}}, 1'b1};

    always_comb begin
        op_ctl.be = be;
        if (!adv_ld) begin
            op_ctl.valid = sel_ok;
            op_ctl.rd    = rd_wr;
            op_addr      = addr;
        end else begin
            op_ctl.valid = b_act;
            op_ctl.rd    = b_rd;
            op_addr      = {b_base[ADDR_W-1:BL], b_off};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_act  <= 1'b0;
            b_rd   <= 1'b0;
            b_base <= '0;
            b_cnt  <= '0;
        end else if (en) begin
            if (!adv_ld) begin
                b_act  <= sel_ok;
                b_rd   <= rd_wr;
                b_base <= addr;
                b_cnt  <= '0;
            end else if (b_act) begin
                b_cnt  <= b_cnt + {{(BL-1){1'b0}}, 1'b1};
            end
        end
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  be_t               wbe,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= lane_merge(mem[waddr], wdata, wbe);
        end
    end

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  op_ctl_t           in_ctl,
    input  logic [ADDR_W-1:0] in_addr,
    input  word_t             bus_wdata,
    input  word_t             arr_rdata,
    output logic [ADDR_W-1:0] arr_raddr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output word_t             arr_wdata,
    output be_t               arr_wbe,
    output logic              ph_rd,
    output word_t             ph_word
);

    // address stage, data-phase stage, and the late-write buffer
    op_ctl_t           s1_ctl, s2_ctl;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic              wb_v;
    logic [ADDR_W-1:0] wb_addr;
    word_t             wb_data;
    be_t               wb_be;
    word_t             rd_hold;
    word_t             fwd;

    assign arr_raddr = s1_addr;
    assign arr_we    = en && wb_v;
    assign arr_waddr = wb_addr;
    assign arr_wdata = wb_data;
    assign arr_wbe   = wb_be;
    assign ph_rd     = s2_ctl.valid && s2_ctl.rd;
    assign ph_word   = rd_hold;

    // array content, then the buffered write (older), then the write in its data phase
    always_comb begin
        fwd = arr_rdata;
        if (wb_v && wb_addr == s1_addr) begin
            fwd = lane_merge(fwd, wb_data, wb_be);
        end
        if (s2_ctl.valid && !s2_ctl.rd && s2_addr == s1_addr) begin
            fwd = lane_merge(fwd, bus_wdata, s2_ctl.be);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl  <= '0;
            s2_ctl  <= '0;
            s1_addr <= '0;
            s2_addr <= '0;
            wb_v    <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
            wb_be   <= '0;
            rd_hold <= '0;
        end else if (en) begin
            s1_ctl  <= in_ctl;
            s1_addr <= in_addr;
            s2_ctl  <= s1_ctl;
            s2_addr <= s1_addr;
            if (s1_ctl.valid && s1_ctl.rd) begin
                rd_hold <= fwd;
            end
            wb_v    <= s2_ctl.valid && !s2_ctl.rd;
            wb_addr <= s2_addr;
            wb_data <= bus_wdata;
            wb_be   <= s2_ctl.be;
        end
    end

endmodule

// File: rtl/zbt_mem_top.sv
module zbt_mem_top
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sel0,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              rd_wr,
    input  logic              adv_ld,
    input  logic [LANES-1:0]  byte_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_BITS-1:0] wdata,
    input  logic              out_en,
    output logic [WORD_BITS-1:0] rdata,
    output logic              rvalid
);

    logic              sel_ok;
    op_ctl_t           op_ctl;
    logic [ADDR_W-1:0] op_addr;
    logic [ADDR_W-1:0] arr_raddr, arr_waddr;
    word_t             arr_rdata, arr_wdata;
    be_t               arr_wbe;
    logic              arr_we;
    logic              ph_rd;
    word_t             ph_word;
    word_t             q_word;
    logic              q_valid;

    assign sel_ok = sel0 && sel1 && !sel2_n;

    zbt_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk     (clk),
        .rst     (rst),
        .en      (clk_en),
        .sel_ok  (sel_ok),
        .rd_wr   (rd_wr),
        .adv_ld  (adv_ld),
        .addr    (addr),
        .be      (byte_we),
        .op_ctl  (op_ctl),
        .op_addr (op_addr)
    );

    zbt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .en        (clk_en),
        .in_ctl    (op_ctl),
        .in_addr   (op_addr),
        .bus_wdata (wdata),
        .arr_rdata (arr_rdata),
        .arr_raddr (arr_raddr),
        .arr_we    (arr_we),
        .arr_waddr (arr_waddr),
        .arr_wdata (arr_wdata),
        .arr_wbe   (arr_wbe),
        .ph_rd     (ph_rd),
        .ph_word   (ph_word)
    );

    zbt_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .wbe   (arr_wbe),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_word  <= '0;
            q_valid <= 1'b0;
        end else if (clk_en) begin
            q_valid <= ph_rd;
            q_word  <= ph_rd ? ph_word : '0;
        end
    end

    assign rdata  = out_en ? q_word : '0;
    assign rvalid = q_valid;

endmodule

// File: rtl/zbt_mem_chk.sv
module zbt_mem_chk
    import zbt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 clk_en,
    input logic                 sel0,
    input logic                 sel1,
    input logic                 sel2_n,
    input logic                 rd_wr,
    input logic                 adv_ld,
    input logic                 out_en,
    input logic [WORD_BITS-1:0] rdata,
    input logic                 rvalid,
    input logic [WORD_BITS-1:0] q_word
);

    logic ld_rd, ld_nodata;
    assign ld_rd     = !adv_ld && sel0 && sel1 && !sel2_n && rd_wr;
    assign ld_nodata = !adv_ld && !(sel0 && sel1 && !sel2_n && rd_wr);

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && !$past(rst) && $past(clk_en && ld_rd, 2) && $past(clk_en) && clk_en)
        |=> rvalid);

    assert_no_data_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 2) && !$past(rst) && $past(clk_en && ld_nodata, 2) && $past(clk_en) && clk_en)
        |=> !rvalid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(q_word) && $stable(rvalid)));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (out_en && !rvalid) |-> (rdata == '0));

    assert_out_off_R9: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (rdata == '0));

endmodule

bind zbt_mem_top zbt_mem_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .sel0   (sel0),
    .sel1   (sel1),
    .sel2_n (sel2_n),
    .rd_wr  (rd_wr),
    .adv_ld (adv_ld),
    .out_en (out_en),
    .rdata  (rdata),
    .rvalid (rvalid),
    .q_word (q_word)
);

// File: tb/tb_zbt_mem_top.sv
`timescale 1ns/1ps
module tb_zbt_mem_top;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst, clk_en, sel0, sel1, sel2_n, rd_wr, adv_ld, out_en;
    logic [3:0]    byte_we;
    logic [AW-1:0] addr;
    logic [35:0]   wdata, rdata;
    logic          rvalid;

    zbt_mem_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sel0(sel0), .sel1(sel1),
        .sel2_n(sel2_n), .rd_wr(rd_wr), .adv_ld(adv_ld), .byte_we(byte_we),
        .addr(addr), .wdata(wdata), .out_en(out_en), .rdata(rdata), .rvalid(rvalid)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit          rd;
        logic [35:0] exp;
        string       tag;
    } item_t;

    item_t       cur_item;
    item_t       sbq[$];
    logic [35:0] wdq[$];
    logic [35:0] ref_mem [DEPTH];
    bit          mb_act, mb_rd;
    logic [AW-1:0] mb_base;
    logic [1:0]  mb_cnt;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;
    logic [35:0] prev_rdata;
    logic        prev_rvalid;
    bit          prev_oe = 0;

    function automatic logic [35:0] rnd36();
        return {$urandom_range(15, 0), $urandom()};
    endfunction

    function automatic logic [35:0] mrg(logic [35:0] o, logic [35:0] n, logic [3:0] be);
        logic [35:0] r = o;
        for (int i = 0; i < 4; i++)
            if (be[i]) begin
                r[i*8 +: 8] = n[i*8 +: 8];
                r[32+i]     = n[32+i];
            end
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit en, bit s0, bit s1, bit s2n, bit rd, bit adv,
                        logic [AW-1:0] a, logic [3:0] be, string tag);
        bit v, r;
        logic [AW-1:0] ea;
        logic [35:0] d;
        @(negedge clk);
        clk_en = en; sel0 = s0; sel1 = s1; sel2_n = s2n; rd_wr = rd;
        adv_ld = adv; addr = a; byte_we = be;
        if (!en) begin
            wdata = rnd36();
            return;
        end
        if (!adv) begin
            v = s0 && s1 && !s2n; r = rd; ea = a;
            mb_act = v; mb_rd = rd; mb_base = a; mb_cnt = 0;
        end else begin
            v = mb_act; r = mb_rd;
            mb_cnt = mb_cnt + 2'd1;
            ea = {mb_base[AW-1:2], mb_base[1:0] + mb_cnt};
        end
        d = rnd36();
        if (v && !r) ref_mem[ea] = mrg(ref_mem[ea], d, be);
        wdq.push_back((v && !r) ? d : rnd36());
        if (wdq.size() > 3) void'(wdq.pop_front());
        wdata = (wdq.size() == 3) ? wdq[0] : rnd36();
        cur_item = '{rd: (v && r), exp: ((v && r) ? ref_mem[ea] : 36'h0), tag: tag};
    endtask

    task automatic wr(logic [AW-1:0] a, logic [3:0] be, string tag);
        step(1, 1, 1, 0, 0, 0, a, be, tag);
    endtask
    task automatic rdq(logic [AW-1:0] a, string tag);
        step(1, 1, 1, 0, 1, 0, a, 4'h0, tag);
    endtask
    task automatic idle(string tag);
        step(1, 0, 1, 0, 1, 0, '0, 4'h0, tag);
    endtask

    // scoreboard monitor: one item per enabled edge, compared two enabled edges later
    always begin
        bit    en_s;
        item_t it_s, it;
        @(posedge clk);
        en_s = clk_en;
        it_s = cur_item;
        #1;
        if (!rst) begin
            if (en_s) begin
                sbq.push_back(it_s);
                if (sbq.size() == 3) begin
                    it = sbq.pop_front();
                    chk(rvalid == it.rd, {it.tag, " rvalid"}, {35'h0, rvalid}, {35'h0, it.rd});
                    if (out_en) begin
                        if (it.rd) chk(rdata === it.exp, {it.tag, " R2 read data"}, rdata, it.exp);
                        else       chk(rdata == 36'h0, {"R10 idle data (", it.tag, ")"}, rdata, 36'h0);
                    end
                end
            end else if (out_en && prev_oe) begin
                chk(rdata === prev_rdata && rvalid == prev_rvalid, "R6 stall hold",
                    rdata, prev_rdata);
            end
        end
        prev_rdata = rdata; prev_rvalid = rvalid; prev_oe = out_en;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a, b;
        logic [35:0] held;
        rst = 1; clk_en = 1; sel0 = 0; sel1 = 1; sel2_n = 0; rd_wr = 1; adv_ld = 0;
        byte_we = 0; addr = 0; wdata = 0; out_en = 1;
        cur_item = '{rd: 0, exp: 36'h0, tag: "init"};
        mb_act = 0; mb_rd = 0; mb_base = 0; mb_cnt = 0;
        repeat (4) @(negedge clk);
        chk(rvalid == 1'b0, "R1 reset rvalid", {35'h0, rvalid}, 36'h0);
        chk(rdata == 36'h0, "R1 reset rdata", rdata, 36'h0);
        rst = 0;

        for (int i = 0; i < DEPTH; i++) wr(i[AW-1:0], 4'hF, "R3 fill");
        for (int i = 0; i < DEPTH; i++) rdq(i[AW-1:0], "R2 readback");

        // R5: alternating directions, forwarding after one and two cycles
        for (int k = 0; k < 12; k++) begin
            a = $urandom_range(DEPTH - 1, 0); b = a + 1;
            wr(a, 4'hF, "R5 wr");   rdq(a, "R5 fwd1");
            wr(a, 4'hF, "R5 wr");   rdq(b, "R5 other"); rdq(a, "R5 fwd2");
            rdq(a, "R5 rd");        wr(a, 4'hF, "R5 wr"); wr(b, 4'hF, "R5 wr"); rdq(a, "R5 fwd2b");
        end

        // R4: byte masks, including two stacked partial writes forwarded together
        for (int k = 0; k < 16; k++) begin
            a = $urandom_range(DEPTH - 1, 0);
            wr(a, k[3:0], "R4 mask");
            wr(a, 4'(~k), "R4 mask");
            rdq(a, "R4 merged");
            idle("R4 gap");
            rdq(a, "R4 settled");
        end

        // R7: each chip enable inactive in turn blocks a write and a read
        for (int k = 0; k < 3; k++) begin
            a = k[AW-1:0];
            step(1, k != 0, k != 1, k == 2, 0, 0, a, 4'hF, "R7 desel wr");
            step(1, k != 0, k != 1, k == 2, 1, 0, a, 4'h0, "R7 desel rd");
            idle("R7 gap");
            rdq(a, "R7 unchanged");
        end

        // R8: accepted accesses finish after deselect
        wr(4'd5, 4'hF, "R8 wr");
        rdq(4'd5, "R8 rd");
        idle("R8 desel"); idle("R8 desel"); idle("R8 desel");

        // R9: asynchronous output enable
        rdq(4'd5, "R9 rd"); idle("R9 gap"); idle("R9 gap");
        @(negedge clk); #0.5;
        held = rdata;
        out_en = 0; #0.5;
        chk(rdata == 36'h0, "R9 out_en off", rdata, 36'h0);
        out_en = 1; #0.5;
        chk(rdata === held, "R9 out_en restore", rdata, held);

        // R11: bursts with every starting offset, and advance after an unselected load
        for (int s = 0; s < 4; s++) begin
            a = 4'(4 * s + s);
            wr(a, 4'hF, "R11 burst wr");
            for (int j = 0; j < 3; j++) step(1, 0, 0, 1, 1, 1, '0, 4'hF, "R11 adv wr");
            rdq(a, "R11 burst rd");
            for (int j = 0; j < 4; j++) step(1, 0, 0, 1, 0, 1, '0, 4'h0, "R11 adv rd");
        end
        idle("R11 off");
        step(1, 1, 1, 0, 1, 1, '0, 4'h0, "R11 adv idle");
        step(1, 1, 1, 0, 0, 1, '0, 4'hF, "R11 adv idle");

        // R6 and random mix
        for (int k = 0; k < 3000; k++) begin
            int p = $urandom_range(99, 0);
            a = $urandom_range(DEPTH - 1, 0);
            if (p < 20)      step(0, 1, 1, 0, $urandom_range(1, 0), 0, a, 4'hF, "R6 stall");
            else if (p < 50) wr(a, 4'($urandom_range(15, 0)), "R5 mix wr");
            else if (p < 85) rdq(a, "R5 mix rd");
            else if (p < 92) step(1, 1, 1, 0, 0, 1, a, 4'($urandom_range(15, 0)), "R11 mix adv");
            else             idle("R10 mix idle");
        end

        for (int k = 0; k < 4; k++) idle("drain");
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule